// File: doc/BRIEF.md
# Dead-Time Gate Sequencer for a Buck/Boost Synchronous Converter

This block turns a commanded duty cycle into two gate commands for a synchronous DC/DC power stage that can be wired either as a step-down or a step-up converter. `dh_n` controls a high-side p-channel switch and is active low. `dl` controls a low-side n-channel switch and is active high. The static topology select decides which of the two is the main switch and which is the synchronous rectifier. Time is divided into switching periods of `PERIOD_CYC` clocks, counted by a free-running phase counter. The main switch conducts at the start of each period. The rectifier conducts in a window that is kept `DEAD_CYC` clocks clear of the main switch on both sides.

The duty command, the rectifier enable and the topology select are taken only at period boundaries, so nothing changes in the middle of a period. The topology select is taken only when the preceding period was idle. The tri-state request switches both devices off on the next clock. Each topology applies its own duty rules. In step-down mode, a large duty request becomes a continuous on-state with the rectifier disabled, and hysteresis controls the return. In step-up mode, the main-switch time is clamped so that the rectifier always keeps a minimum conduction time.

Top module: `gate_seq`

## Requirements
- R1: While `rst` is high, and for the whole first period after `rst` falls, `dh_n`=1 and `dl`=0. The topology select is captured during reset.
- R2: With `boost_sel`=0 (step-down), `dh_n` is the main switch. It is low for the first M phases of a period, where M = floor(min(duty_pct,100)·PERIOD_CYC/100). The phase counter runs from 0 to PERIOD_CYC-1, and both outputs show phase p one clock after the counter holds p.
- R3: With `boost_sel`=1 (step-up), the roles swap: `dl` is high as the main switch, and `dh_n` is low as the rectifier.
- R4: The rectifier conducts for phases M+DEAD_CYC up to PERIOD_CYC-DEAD_CYC-1. Each output turns on only after the other one has been off for at least DEAD_CYC clocks. The two devices are never on together.
- R5: A high `tri_req` drives `dh_n`=1 and `dl`=0 on the next clock. A period runs only if `tri_req` was low in the last clock of the period before it.
- R6: If `sr_en`=0 is sampled at a period boundary, the rectifier stays off for the whole of that period.
- R7: In step-down mode, if duty_pct > 80 is sampled at a boundary, the main switch is on for the whole period and the rectifier is off. If duty_pct = 80 is sampled, the previous state is kept. If duty_pct < 80 is sampled, normal switching returns.
- R8: In step-up mode, duty_pct is clamped to 70 before M is computed. M is also limited to PERIOD_CYC-2·DEAD_CYC-MIN_RECT_CYC.
- R9: In step-up mode with `sr_en`=1, the rectifier conducts for at least MIN_RECT_CYC clocks in every running period.
- R10: A change of `boost_sel` while periods are running has no effect. The new value is taken at the first boundary that follows an idle period.
- R11: Changes of `duty_pct` or `sr_en` in the middle of a period have no effect until the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| boost_sel | input | 1 | Topology select: 0 = step-down, 1 = step-up |
| sr_en | input | 1 | Synchronous rectifier enable (0 = pulse-skipping, rectifier off) |
| tri_req | input | 1 | Tri-state request: both switches off |
| duty_pct | input | 7 | Commanded main-switch duty in percent (values above 100 are treated as 100) |
| dh_n | output | 1 | High-side p-channel gate, active low |
| dl | output | 1 | Low-side n-channel gate, active high |

## Verification
The step-down duty is swept through 0, 20, 40, 60 and 80 percent. This separates the main-window width from the rectifier window, and the 80 percent case shows the dead-time gap at its tightest. A sequence of 90, 100, 80, 79 and 80 percent shows whether the continuous-on state sets, holds at the threshold and clears. Duty and enable changes made in the middle of a period, tri-state pulses both short and long, and a topology flip made while running show whether sampling happens only at boundaries. Step-up runs at 50, 100 and 70 percent, with the rectifier on and off, show the role swap, the clamp and the minimum rectifier time.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

    localparam int CNT_W = 16;
    localparam int PCT_W = 7;

    // Per-period configuration, captured at each period boundary
    typedef struct packed {
        logic             run;     // period is allowed to switch
        logic             boost;   // topology in force
        logic             sr;      // rectifier allowed
        logic             full;    // step-down continuous-on state
        logic [CNT_W-1:0] on_cnt;  // main-switch phases
    } per_cfg_t;

    typedef struct packed {
        logic main_on;
        logic rect_on;
    } gate_req_t;

    function automatic logic [PCT_W-1:0] pct_clip(input logic [PCT_W-1:0] pct,
                                                  input int unsigned lim);
        return (int'(pct) > lim) ? PCT_W'(lim) : pct;
    endfunction

    function automatic logic [CNT_W-1:0] pct_to_cnt(input logic [PCT_W-1:0] pct,
                                                    input int unsigned period);
        int unsigned p;
        p = (int'(pct) > 100) ? 100 : int'(pct);
        return CNT_W'((p * period) / 100);
    endfunction

endpackage

// File: rtl/gate_seq_phase.sv
module gate_seq_phase
    import gate_seq_pkg::*;
#(
    parameter int PERIOD_CYC = 50
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] ph,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

    assign wrap = (ph == LAST);

    always_ff @(posedge clk) begin
        if (rst)       ph <= '0;
        else if (wrap) ph <= '0;
        else           ph <= ph + 1'b1;
    end
endmodule

// File: rtl/gate_seq_cfg.sv
module gate_seq_cfg
    import gate_seq_pkg::*;
#(
    parameter int PERIOD_CYC    = 50,
    parameter int DEAD_CYC      = 3,
    parameter int MIN_RECT_CYC  = 2,
    parameter int BUCK_JUMP_PCT = 80,
    parameter int BOOST_MAX_PCT = 70
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wrap,
    input  logic             boost_sel,
    input  logic             sr_en,
    input  logic             tri_req,
    input  logic [PCT_W-1:0] duty_pct,
    output per_cfg_t         cfg_q
);
    localparam logic [CNT_W-1:0] BOOST_CAP =
        CNT_W'(PERIOD_CYC - 2*DEAD_CYC - MIN_RECT_CYC);
    localparam logic [PCT_W-1:0] JUMP = PCT_W'(BUCK_JUMP_PCT);

    per_cfg_t         nxt;
    logic [CNT_W-1:0] boost_cnt;

    always_comb begin
        nxt       = cfg_q;
        nxt.run   = ~tri_req;
        nxt.sr    = sr_en;
        nxt.boost = cfg_q.run ? cfg_q.boost : boost_sel;
        boost_cnt = pct_to_cnt(pct_clip(duty_pct, BOOST_MAX_PCT), PERIOD_CYC);
        if (nxt.boost) begin
            nxt.full   = 1'b0;
            nxt.on_cnt = (boost_cnt > BOOST_CAP) ? BOOST_CAP : boost_cnt;
        end else begin
            if (duty_pct > JUMP)      nxt.full = 1'b1;
            else if (duty_pct < JUMP) nxt.full = 1'b0;
            nxt.on_cnt = pct_to_cnt(duty_pct, PERIOD_CYC);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.run    <= 1'b0;
            cfg_q.boost  <= boost_sel;
            cfg_q.sr     <= 1'b0;
            cfg_q.full   <= 1'b0;
            cfg_q.on_cnt <= '0;
        end else if (wrap) begin
            cfg_q <= nxt;
        end
    end
endmodule

// File: rtl/gate_seq_drive.sv
module gate_seq_drive
    import gate_seq_pkg::*;
#(
    parameter int PERIOD_CYC = 50,
    parameter int DEAD_CYC   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] ph,
    input  per_cfg_t         cfg,
    input  logic             tri_req,
    output logic             dh_n,
    output logic             dl
);
    localparam logic [CNT_W-1:0] RECT_END = CNT_W'(PERIOD_CYC - DEAD_CYC);

    gate_req_t        req;
    logic             act;
    logic [CNT_W-1:0] rect_start;
    logic             hi_on;
    logic             lo_on;

    always_comb begin
        act         = cfg.run & ~tri_req;
        rect_start  = cfg.on_cnt + CNT_W'(DEAD_CYC);
        req.main_on = act & (cfg.full | (ph < cfg.on_cnt));
        req.rect_on = act & cfg.sr & ~cfg.full &
                      (ph >= rect_start) & (ph < RECT_END);
        // step-down: high side is main; step-up: low side is main
        hi_on = cfg.boost ? req.rect_on : req.main_on;
        lo_on = cfg.boost ? req.main_on : req.rect_on;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dh_n <= 1'b1;
            dl   <= 1'b0;
        end else begin
            dh_n <= ~hi_on;
            dl   <= lo_on;
        end
    end
endmodule

// File: rtl/gate_seq.sv
module gate_seq
    import gate_seq_pkg::*;
#(
    parameter int PERIOD_CYC    = 50,
    parameter int DEAD_CYC      = 3,
    parameter int MIN_RECT_CYC  = 2,
    parameter int BUCK_JUMP_PCT = 80,
    parameter int BOOST_MAX_PCT = 70
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boost_sel,
    input  logic             sr_en,
    input  logic             tri_req,
    input  logic [PCT_W-1:0] duty_pct,
    output logic             dh_n,
    output logic             dl
);
    logic [CNT_W-1:0] ph;
    logic             wrap;
    per_cfg_t         cfg_q;

    gate_seq_phase #(.PERIOD_CYC(PERIOD_CYC)) u_phase (
        .clk (clk),
        .rst (rst),
        .ph  (ph),
        .wrap(wrap)
    );

    gate_seq_cfg #(
        .PERIOD_CYC   (PERIOD_CYC),
        .DEAD_CYC     (DEAD_CYC),
        .MIN_RECT_CYC (MIN_RECT_CYC),
        .BUCK_JUMP_PCT(BUCK_JUMP_PCT),
        .BOOST_MAX_PCT(BOOST_MAX_PCT)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wrap     (wrap),
        .boost_sel(boost_sel),
        .sr_en    (sr_en),
        .tri_req  (tri_req),
        .duty_pct (duty_pct),
        .cfg_q    (cfg_q)
    );

    gate_seq_drive #(
        .PERIOD_CYC(PERIOD_CYC),
        .DEAD_CYC  (DEAD_CYC)
    ) u_drive (
        .clk    (clk),
        .rst    (rst),
        .ph     (ph),
        .cfg    (cfg_q),
        .tri_req(tri_req),
        .dh_n   (dh_n),
        .dl     (dl)
    );
endmodule

// File: rtl/gate_seq_chk.sv
module gate_seq_chk #(
    parameter int DEAD_CYC = 3
) (
    input logic clk,
    input logic rst,
    input logic tri_req,
    input logic dh_n,
    input logic dl,
    input logic cfg_boost,
    input logic cfg_sr,
    input logic cfg_full
);
    // cycles each device has been off, saturating
    logic [7:0] hi_off;
    logic [7:0] lo_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_off <= '0;
            lo_off <= '0;
        end else begin
            hi_off <= !dh_n ? 8'd0 : ((hi_off == 8'hFF) ? hi_off : hi_off + 8'd1);
            lo_off <= dl    ? 8'd0 : ((lo_off == 8'hFF) ? lo_off : lo_off + 8'd1);
        end
    end

    assert_reset_safe_R1: assert property (@(posedge clk)
        rst |=> (dh_n && !dl));

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        !(!dh_n && dl));

    assert_hi_dead_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(dh_n) |-> (int'(lo_off) >= DEAD_CYC));

    assert_lo_dead_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(dl) |-> (int'(hi_off) >= DEAD_CYC));

    assert_tri_off_R5: assert property (@(posedge clk) disable iff (rst)
        tri_req |=> (dh_n && !dl));

    assert_psm_buck_R6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_sr && !cfg_boost) |=> !dl);

    assert_psm_boost_R6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_sr && cfg_boost) |=> dh_n);

    assert_full_no_rect_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_full && !cfg_boost) |=> !dl);
endmodule

bind gate_seq gate_seq_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tri_req  (tri_req),
    .dh_n     (dh_n),
    .dl       (dl),
    .cfg_boost(cfg_q.boost),
    .cfg_sr   (cfg_q.sr),
    .cfg_full (cfg_q.full)
);

// File: tb/gate_seq_tb_top.sv
module gate_seq_tb_top;
    localparam int CLK_PER = 10;
    localparam int PER     = 50;
    localparam int DT      = 3;
    localparam int MINR    = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       boost_sel = 1'b0;
    logic       sr_en = 1'b1;
    logic       tri_req = 1'b0;
    logic [6:0] duty_pct = 7'd40;
    logic       dh_n;
    logic       dl;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";
    bit    started = 0;
    bit    done = 0;

    // reference model state
    int m_ph, m_on, d;
    bit m_run, m_boost, m_sr, m_full;
    bit act, main_on, rect_on;
    bit exp_dh_n = 1, exp_dl = 0;

    always #(CLK_PER/2) clk = ~clk;

    gate_seq #(.PERIOD_CYC(PER), .DEAD_CYC(DT), .MIN_RECT_CYC(MINR)) dut_i (
        .clk(clk), .rst(rst), .boost_sel(boost_sel), .sr_en(sr_en),
        .tri_req(tri_req), .duty_pct(duty_pct), .dh_n(dh_n), .dl(dl)
    );

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_ph = 0; m_run = 0; m_boost = boost_sel; m_sr = 0; m_full = 0; m_on = 0;
            exp_dh_n = 1; exp_dl = 0;
        end else begin
            act     = m_run && !tri_req;
            main_on = act && (m_full || m_ph < m_on);
            rect_on = act && m_sr && !m_full && (m_ph >= m_on + DT) && (m_ph < PER - DT);
            exp_dh_n = m_boost ? !rect_on : !main_on;
            exp_dl   = m_boost ? main_on : rect_on;
            if (m_ph == PER - 1) begin
                if (!m_run) m_boost = boost_sel;
                m_run = !tri_req;
                m_sr  = sr_en;
                if (m_boost) begin
                    m_full = 0;
                    d = (duty_pct > 70) ? 70 : int'(duty_pct);
                    m_on = d * PER / 100;
                    if (m_on > PER - 2*DT - MINR) m_on = PER - 2*DT - MINR;
                end else begin
                    if (duty_pct > 80) m_full = 1;
                    else if (duty_pct < 80) m_full = 0;
                    d = (duty_pct > 100) ? 100 : int'(duty_pct);
                    m_on = d * PER / 100;
                end
                m_ph = 0;
            end else begin
                m_ph = m_ph + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            total++;
            if (dh_n !== exp_dh_n || dl !== exp_dl) begin
                bad++;
                $display("FAIL %s t=%0t dh_n/dl actual=%b%b expected=%b%b",
                         cur_req, $time, dh_n, dl, exp_dh_n, exp_dl);
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PER * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        run(3);
        // R1: explicit reset-state check
        total++;
        if (dh_n !== 1'b1 || dl !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset actual=%b%b expected=10", dh_n, dl);
        end
        rst = 1'b0;
        cur_req = "R1"; run(60);
        cur_req = "R2"; run(100);
        duty_pct = 7'd0;  run(100);
        duty_pct = 7'd60; run(100);
        cur_req = "R4"; duty_pct = 7'd80; run(100);
        cur_req = "R11"; duty_pct = 7'd20; run(27);
        duty_pct = 7'd60; sr_en = 1'b0; run(13); sr_en = 1'b1; run(90);
        cur_req = "R6"; sr_en = 1'b0; run(100); sr_en = 1'b1;
        cur_req = "R7"; duty_pct = 7'd90; run(100);
        duty_pct = 7'd100; run(100);
        duty_pct = 7'd80;  run(100);
        duty_pct = 7'd79;  run(100);
        duty_pct = 7'd80;  run(100);
        cur_req = "R5"; duty_pct = 7'd40; tri_req = 1'b1; run(7); tri_req = 1'b0; run(120);
        tri_req = 1'b1; run(60); tri_req = 1'b0; run(120);
        cur_req = "R10"; boost_sel = 1'b1; run(150);
        cur_req = "R3"; tri_req = 1'b1; run(60); tri_req = 1'b0; duty_pct = 7'd50; run(150);
        cur_req = "R8"; duty_pct = 7'd100; run(150);
        cur_req = "R9"; duty_pct = 7'd70; run(100);
        cur_req = "R6"; sr_en = 1'b0; run(100);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule